// File: doc/BRIEF.md
# DMA Channel Status Register and Interrupt Combiner

This block keeps one 32-bit control/status word per DMA channel and turns the flags inside those words into one interrupt line and a summary vector with one bit per channel. Software reaches the words through a simple write port and a combinational read port. The transfer engine and the request mapper reach them through per-channel event strobes. The block drives the channel controls (run, descriptor-fetch bypass, end-of-receive stop and jump, compare status) back to the engine.

The bits of a status word fall into three classes. Event flags are set by hardware and cleared when software writes a one to them. Control bits take their value straight from each write and are zero when a write leaves them clear. Strobe bits are not stored at all: they set or clear another bit. Only some flags pass through an enable before they reach the interrupt. The start and end flags always interrupt. The stop, end-of-receive and request-after-start flags each need their enable bit.

Top module: `dma_chstat_irq`

## Requirements
- R1: After reset every channel reads 0x00000008, with only the stop flag (bit 3) set. The summary vector and the interrupt are 0.
- R2: A write to a channel clears flag bits 0, 1, 2 and 9 where the written data has a one. It keeps flag bits 3, 4 and 10 unless another rule changes them.
- R3: A write loads control bits 23 and 26 to 31 directly from the written data. Bits 5 to 7, 11 to 22, 24 and 25 always read 0. Bit 8 reads 0 unless R7 applies.
- R4: If bit 29 (stop interrupt enable) is 1 in the word that results from a write, that write clears the stop flag (bit 3).
- R5: A write with bit 31 (run) set clears the stop flag. A write with both bit 31 and bit 22 (mask-run) clear sets the stop flag, and this takes precedence over R4.
- R6: A write with bit 24 set clears compare status (bit 10). A write with bit 25 set sets it. When both are set, bit 25 wins.
- R7: The read port returns the stored word of channel `rd_ch`, with bit 8 forced to 1 while that channel's `req_active` input is high.
- R8: The event strobes set flags as follows: bus error sets bit 0, start sets bit 1, end sets bit 2, stop sets bit 3, request-after-start sets bit 4 and end-of-receive sets bit 9. The halt strobe clears bit 31. When a write lands in the same cycle, events apply after it. A channel with no write and no event holds its word.
- R9: A channel's contribution is 1 when any of these holds: bit 3 and bit 29, bit 9 and bit 28, bit 4 and bit 23, bit 1, or bit 2. `irq_sum[c]` is channel c's contribution and `irq` is the OR of all contributions. Both are registered, one clock after the status words.
- R10: For each channel, `run` shows bit 31, `no_fetch` shows bit 30, `eor_stop` shows bit 26, `eor_jump` shows bit 27 and `cmp_st` shows bit 10 of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for one status word |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_data | input | 32 | Written value |
| rd_ch | input | CH_W | Channel addressed by the read |
| rd_data | output | 32 | Status word of `rd_ch`, with the live request-pending bit |
| ev_buserr | input | NUM_CH | Bus error event per channel |
| ev_start | input | NUM_CH | Descriptor start event per channel |
| ev_end | input | NUM_CH | Transfer end event per channel |
| ev_stop | input | NUM_CH | Channel stopped event per channel |
| ev_ras | input | NUM_CH | Request-after-start event per channel |
| ev_eor | input | NUM_CH | End-of-receive event per channel |
| ev_halt | input | NUM_CH | Engine clears the run bit per channel |
| req_active | input | NUM_CH | Mapped peripheral request is active per channel |
| run | output | NUM_CH | Run control per channel |
| no_fetch | output | NUM_CH | Descriptor fetch bypass per channel |
| eor_stop | output | NUM_CH | Stop on end-of-receive per channel |
| eor_jump | output | NUM_CH | Jump to next descriptor on end-of-receive per channel |
| cmp_st | output | NUM_CH | Compare status per channel |
| irq_sum | output | NUM_CH | Registered per-channel interrupt contribution |
| irq | output | 1 | Registered combined interrupt |

## Verification
Several rules are checked on every cycle. These are the reserved bits staying zero, the effect of the run and mask-run bits on the stop flag, the compare set and clear strobes, write-one-to-clear of the bus error flag, holding a word when nothing touches it, and the agreement between `irq` and the summary vector. Other behaviours only show up in the bench's scenarios. These include the exact word that results from each one-hot write after all flags have been raised, the interplay of the stop enable with the run rules, events that land in the same cycle as a write, the request-pending bit on the read, and the one-cycle lag of the registered interrupt outputs.

// File: rtl/dma_chstat_pkg.sv
package dma_chstat_pkg;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned B_BUSERR  = 0;
  localparam int unsigned B_START   = 1;
  localparam int unsigned B_END     = 2;
  localparam int unsigned B_STOP    = 3;
  localparam int unsigned B_RAS     = 4;
  localparam int unsigned B_REQPND  = 8;
  localparam int unsigned B_EOR     = 9;
  localparam int unsigned B_CMP     = 10;
  localparam int unsigned B_MASKRUN = 22;
  localparam int unsigned B_RASIE   = 23;
  localparam int unsigned B_CMPCLR  = 24;
  localparam int unsigned B_CMPSET  = 25;
  localparam int unsigned B_EORSTOP = 26;
  localparam int unsigned B_EORJUMP = 27;
  localparam int unsigned B_EORIE   = 28;
  localparam int unsigned B_STOPIE  = 29;
  localparam int unsigned B_NOFETCH = 30;
  localparam int unsigned B_RUN     = 31;

  // flags kept across a write
  localparam logic [WORD_W-1:0] KEEP_MASK  = 32'h0000_071F;
  // flags cleared by writing one
  localparam logic [WORD_W-1:0] W1C_MASK   = 32'h0000_0207;
  // control bits loaded from the write
  localparam logic [WORD_W-1:0] LOAD_MASK  = 32'hFC80_0000;
  localparam logic [WORD_W-1:0] STORE_MASK = KEEP_MASK | LOAD_MASK;
  localparam logic [WORD_W-1:0] RST_WORD   = 32'h0000_0008;

  typedef struct packed {
    logic buserr;
    logic start;
    logic fin;
    logic stop;
    logic ras;
    logic eor;
    logic halt;
  } chan_ev_t;

  function automatic logic irq_contrib(input logic [WORD_W-1:0] w);
    return (w[B_STOP] & w[B_STOPIE]) | (w[B_EOR] & w[B_EORIE]) |
           (w[B_RAS] & w[B_RASIE]) | w[B_START] | w[B_END];
  endfunction
endpackage

// File: rtl/dma_chstat_reg.sv
module dma_chstat_reg
  import dma_chstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_data,
  input  chan_ev_t          ev,
  output logic [WORD_W-1:0] state_o,
  output logic              irq_req_o
);
  logic [WORD_W-1:0] state_q;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] state_d;
  logic              state_en;

  always_comb begin
    wr_word = (state_q & KEEP_MASK & ~(wr_data & W1C_MASK)) | (wr_data & LOAD_MASK);
    if (wr_word[B_STOPIE])                          wr_word[B_STOP] = 1'b0;
    if (wr_data[B_RUN])                             wr_word[B_STOP] = 1'b0;
    if (!wr_data[B_RUN] && !wr_data[B_MASKRUN])     wr_word[B_STOP] = 1'b1;
    if (wr_data[B_CMPCLR])                          wr_word[B_CMP]  = 1'b0;
    if (wr_data[B_CMPSET])                          wr_word[B_CMP]  = 1'b1;
  end

  always_comb begin
    state_d = wr_hit ? wr_word : state_q;
    if (ev.buserr) state_d[B_BUSERR] = 1'b1;
    if (ev.start)  state_d[B_START]  = 1'b1;
    if (ev.fin)    state_d[B_END]    = 1'b1;
    if (ev.stop)   state_d[B_STOP]   = 1'b1;
    if (ev.ras)    state_d[B_RAS]    = 1'b1;
    if (ev.eor)    state_d[B_EOR]    = 1'b1;
    if (ev.halt)   state_d[B_RUN]    = 1'b0;
  end

  assign state_en = wr_hit | ev.buserr | ev.start | ev.fin | ev.stop |
                    ev.ras | ev.eor | ev.halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= RST_WORD;
    else if (state_en) state_q <= state_d;
  end

  assign state_o   = state_q;
  assign irq_req_o = irq_contrib(state_q);

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q & ~STORE_MASK) == '0);
  // R5
  run_clr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data[B_RUN] && !ev.stop) |=> !state_q[B_STOP]);
  // R5
  idle_set_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wr_data[B_RUN] && !wr_data[B_MASKRUN]) |=> state_q[B_STOP]);
  // R6
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data[B_CMPSET]) |=> state_q[B_CMP]);
  // R6
  cmp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data[B_CMPCLR] && !wr_data[B_CMPSET]) |=> !state_q[B_CMP]);
  // R2
  w1c_buserr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data[B_BUSERR] && !ev.buserr) |=> !state_q[B_BUSERR]);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !state_en |=> $stable(state_q));
endmodule

// File: rtl/dma_chstat_merge.sv
module dma_chstat_merge #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_req,
  output logic [NUM_CH-1:0] irq_sum,
  output logic              irq
);
  logic [NUM_CH-1:0] sum_q;
  logic              irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= irq_req;
      irq_q <= |irq_req;
    end
  end

  assign irq_sum = sum_q;
  assign irq     = irq_q;

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|irq_sum));
endmodule

// File: rtl/dma_chstat_irq.sv
module dma_chstat_irq
  import dma_chstat_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [31:0]       wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [31:0]       rd_data,
  input  logic [NUM_CH-1:0] ev_buserr,
  input  logic [NUM_CH-1:0] ev_start,
  input  logic [NUM_CH-1:0] ev_end,
  input  logic [NUM_CH-1:0] ev_stop,
  input  logic [NUM_CH-1:0] ev_ras,
  input  logic [NUM_CH-1:0] ev_eor,
  input  logic [NUM_CH-1:0] ev_halt,
  input  logic [NUM_CH-1:0] req_active,
  output logic [NUM_CH-1:0] run,
  output logic [NUM_CH-1:0] no_fetch,
  output logic [NUM_CH-1:0] eor_stop,
  output logic [NUM_CH-1:0] eor_jump,
  output logic [NUM_CH-1:0] cmp_st,
  output logic [NUM_CH-1:0] irq_sum,
  output logic              irq
);
  logic [WORD_W-1:0] word [NUM_CH];
  logic [NUM_CH-1:0] irq_req;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_ev_t ev_c;
    logic     hit_c;

    assign hit_c = wr_en && (wr_ch == CH_W'(c));
    assign ev_c  = '{buserr: ev_buserr[c], start: ev_start[c], fin: ev_end[c],
                     stop: ev_stop[c], ras: ev_ras[c], eor: ev_eor[c],
                     halt: ev_halt[c]};

    dma_chstat_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (hit_c),
      .wr_data   (wr_data),
      .ev        (ev_c),
      .state_o   (word[c]),
      .irq_req_o (irq_req[c])
    );

    assign run[c]      = word[c][B_RUN];
    assign no_fetch[c] = word[c][B_NOFETCH];
    assign eor_stop[c] = word[c][B_EORSTOP];
    assign eor_jump[c] = word[c][B_EORJUMP];
    assign cmp_st[c]   = word[c][B_CMP];

    // R9
    stop_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word[c][B_STOP] && word[c][B_STOPIE]) |=> irq_sum[c]);
    // R9
    start_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word[c][B_START] |=> irq_sum[c]);
  end

  always_comb begin
    rd_data = '0;
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      if (rd_ch == CH_W'(c)) begin
        rd_data = word[c];
        if (req_active[c]) rd_data[B_REQPND] = 1'b1;
      end
    end
  end

  dma_chstat_merge #(.NUM_CH(NUM_CH)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .irq_sum (irq_sum),
    .irq     (irq)
  );
endmodule

// File: tb/dma_chstat_irq_bench.sv
module dma_chstat_irq_bench;
  localparam int N  = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [CW-1:0] wr_ch = '0;
  logic [31:0]   wr_data = '0;
  logic [CW-1:0] rd_ch = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  ev_buserr = '0, ev_start = '0, ev_end = '0, ev_stop = '0;
  logic [N-1:0]  ev_ras = '0, ev_eor = '0, ev_halt = '0, req_active = '0;
  logic [N-1:0]  run, no_fetch, eor_stop, eor_jump, cmp_st, irq_sum;
  logic          irq;

  int vectors = 0;
  int fails   = 0;
  logic [31:0] mdl [N];

  always #2 clk = ~clk;

  dma_chstat_irq #(.NUM_CH(N)) u_dma_chstat_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .ev_buserr(ev_buserr), .ev_start(ev_start),
    .ev_end(ev_end), .ev_stop(ev_stop), .ev_ras(ev_ras), .ev_eor(ev_eor),
    .ev_halt(ev_halt), .req_active(req_active), .run(run), .no_fetch(no_fetch),
    .eor_stop(eor_stop), .eor_jump(eor_jump), .cmp_st(cmp_st),
    .irq_sum(irq_sum), .irq(irq));

  function automatic logic [31:0] exp_write(input logic [31:0] old, input logic [31:0] d);
    logic [31:0] n;
    n = (old & 32'h0000_071F & ~(d & 32'h0000_0207)) | (d & 32'hFC80_0000);
    if (n[29]) n[3] = 1'b0;
    if (d[31]) n[3] = 1'b0;
    if (!d[31] && !d[22]) n[3] = 1'b1;
    if (d[24]) n[10] = 1'b0;
    if (d[25]) n[10] = 1'b1;
    return n;
  endfunction

  // event mask bits: 0 buserr,1 start,2 end,3 stop,4 ras,5 eor,6 halt
  function automatic logic [31:0] exp_event(input logic [31:0] w, input logic [6:0] e);
    logic [31:0] n;
    n = w;
    if (e[0]) n[0] = 1'b1;
    if (e[1]) n[1] = 1'b1;
    if (e[2]) n[2] = 1'b1;
    if (e[3]) n[3] = 1'b1;
    if (e[4]) n[4] = 1'b1;
    if (e[5]) n[9] = 1'b1;
    if (e[6]) n[31] = 1'b0;
    return n;
  endfunction

  function automatic logic exp_irq(input logic [31:0] w);
    return (w[3] & w[29]) | (w[9] & w[28]) | (w[4] & w[23]) | w[1] | w[2];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: optional write plus events on channel ch
  task automatic step(input int ch, input logic we, input logic [31:0] d, input logic [6:0] e);
    @(negedge clk);
    wr_en = we; wr_ch = CW'(ch); wr_data = d;
    ev_buserr[ch] = e[0]; ev_start[ch] = e[1]; ev_end[ch] = e[2]; ev_stop[ch] = e[3];
    ev_ras[ch] = e[4]; ev_eor[ch] = e[5]; ev_halt[ch] = e[6];
    @(posedge clk);
    #1;
    wr_en = 1'b0; ev_buserr = '0; ev_start = '0; ev_end = '0; ev_stop = '0;
    ev_ras = '0; ev_eor = '0; ev_halt = '0;
    if (we) mdl[ch] = exp_write(mdl[ch], d);
    mdl[ch] = exp_event(mdl[ch], e);
  endtask

  task automatic verify(input int ch, input logic req);
    logic [31:0] rexp;
    logic [N-1:0] sexp;
    rd_ch = CW'(ch);
    req_active = '0;
    req_active[ch] = req;
    @(negedge clk);
    rexp = mdl[ch];
    if (req) rexp[8] = 1'b1;
    check(req ? "R7 read with request" : "R2 R3 R4 R5 R6 R8 read", rd_data, rexp);
    check("R10 controls", {27'd0, run[ch], no_fetch[ch], eor_stop[ch], eor_jump[ch], cmp_st[ch]},
          {27'd0, mdl[ch][31], mdl[ch][30], mdl[ch][26], mdl[ch][27], mdl[ch][10]});
    @(negedge clk);
    for (int c = 0; c < N; c++) sexp[c] = exp_irq(mdl[c]);
    check("R9 summary", {28'd0, irq_sum}, {28'd0, sexp});
    check("R9 irq", {31'd0, irq}, {31'd0, |sexp});
    req_active = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < N; c++) mdl[c] = 32'h0000_0008;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int c = 0; c < N; c++) begin
      rd_ch = CW'(c);
      #1;
      check("R1 reset word", rd_data, 32'h0000_0008);
    end
    check("R1 reset irq", {27'd0, irq_sum, irq}, 32'd0);

    // one-hot write sweep after raising every flag
    for (int c = 0; c < N; c++) begin
      for (int b = 0; b < 32; b++) begin
        step(c, 1'b0, 32'd0, 7'h3F);
        step(c, 1'b1, 32'd1 << b, 7'h00);
        verify(c, b[0]);
      end
    end

    // combined control patterns, with events before or alongside the write
    for (int c = 0; c < N; c++) begin
      for (int k = 0; k < 64; k++) begin
        logic [31:0] d;
        logic [6:0]  e;
        d = ({31'd0, k[0]} << 31) | ({31'd0, k[1]} << 29) | ({31'd0, k[2]} << 22) |
            ({31'd0, k[3]} << 24) | ({31'd0, k[4]} << 25) | ({31'd0, k[5]} << 28) |
            ({31'd0, k[5]} << 23) | (k[1] ? 32'h0000_0207 : 32'd0) | 32'h4C00_0000;
        e = 7'((k * 5 + c) & 7'h7F);
        if (k[0] ^ k[3]) begin
          step(c, 1'b1, d, e);        // R8 events after same-cycle write
        end else begin
          step(c, 1'b0, 32'd0, e);
          step(c, 1'b1, d, 7'h00);
        end
        verify(c, k[2]);
      end
    end

    // halt clears run, other channels undisturbed
    step(1, 1'b1, 32'h8000_0000, 7'h00);
    verify(1, 1'b0);
    step(1, 1'b0, 32'd0, 7'h40);
    verify(1, 1'b0);
    check("R8 halt run", {31'd0, run[1]}, 32'd0);
    for (int c = 0; c < N; c++) verify(c, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule